// File: doc/BRIEF.md
# Half-Duplex Buffered SPI Master Engine

This block is an SPI master driven through a small word-addressed register set. Software loads a command word, fills a 32-byte data buffer, programs one packed length register and sets a start bit. The engine then runs one half-duplex transaction. It first shifts out a command/address phase taken from the command word. It then shifts out an optional extra-write phase taken from the data buffer. Finally it shifts in an optional read phase, and the received bytes land back in the same data buffer. Software polls a busy flag and reads the received bytes out of the buffer.

Chip select is a separate register bit that software drives directly. Starting or finishing a transaction never touches it. A long bus message can therefore be cut into several transactions while the slave stays selected. Serial timing is SPI mode 0: SCLK idles low, MISO is captured on the rising edge, and MOSI moves only while SCLK is low. The SCLK half period is a fixed number of system clocks set by a parameter.

Top module: `hdx_spi_engine`

## Requirements
- R1: After synchronous reset, every register reads zero, the busy bit reads 0, `spi_cs_n` is 1, and `spi_sclk` and `spi_mosi` are 0.
- R2: The register map is word-addressed. The command word is at 0x00. Data words 0..7 are at 0x04..0x20. The length register is at 0x24. Control/status is at 0x28: a write of bit 0 = 1 starts a transaction, and a read of bit 0 is busy. Chip select is at 0x2C, bit 0. The command word, the data words and the length register read back the value last written.
- R3: Length register fields, all counted in bits: command bits in [31:24], read bits in [20:12], extra-write bits in [8:0]. A command count above 32 is treated as 32. A write or read count above 256 is treated as 256. The number of SCLK pulses equals the sum of the effective counts.
- R4: Phases run in the fixed order command, extra-write, read, and a zero-length phase is skipped. Extra-write bytes come from data-buffer byte 0 upward. MOSI is 0 during the read phase.
- R5: The command word is shifted from bit 31 downward, so its most significant byte goes first. A command shorter than 4 bytes must be left-aligned in the word.
- R6: Data-buffer byte k is bits [8(k%4)+7 : 8(k%4)] of data word k/4. Bytes are sent in increasing k, each byte most-significant bit first.
- R7: Read bits are stored from data-buffer byte 0 upward, using the layout of R6. The first bit received in a byte becomes its bit 7.
- R8: SPI mode 0. SCLK is low whenever the engine is idle. Consecutive SCLK rising edges inside a transaction are 2*SCLK_HALF clocks apart. MOSI never changes while SCLK is high.
- R9: Busy reads 1 on the cycle after the start write and drops after the last bit has been clocked. With all three counts zero, busy is high for exactly one cycle and no SCLK pulse occurs.
- R10: While busy, writes to the command word, the data words and the length register are ignored, and a start write does not launch another transaction.
- R11: `spi_cs_n` is always the inverse of chip-select bit 0. That bit is writable at any time, including while busy, and is never changed by a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address (word-aligned) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the engine with SCLK_HALF = 3. With that value the divider counter passes through intermediate values, and the six-clock SCLK period can be told apart from off-by-one divider errors. The buffer sizes stay at their package values of 4 command bytes and 32 data bytes. This puts the limit cases within reach: a 36-byte write, a full 32-byte read, and counts above the field limits that must clamp. A slave model streams a known byte pattern on MISO, and a scoreboard compares every MOSI byte against what the requirements predict.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    localparam int OP_BYTES   = 4;
    localparam int DBUF_BYTES = 32;
    localparam int OP_BITS    = OP_BYTES * 8;
    localparam int DBUF_BITS  = DBUF_BYTES * 8;
    localparam int DBUF_WORDS = DBUF_BYTES / 4;
    localparam int CNT_W      = $clog2(DBUF_BITS + 1);
    localparam int IDX_W      = $clog2(DBUF_BITS);
    localparam int ADDR_W     = 6;

    localparam logic [CNT_W-1:0] OP_MAX = CNT_W'(OP_BITS);
    localparam logic [CNT_W-1:0] DB_MAX = CNT_W'(DBUF_BITS);

    localparam logic [ADDR_W-1:0] A_OPC  = 6'h00;
    localparam logic [ADDR_W-1:0] A_DAT0 = 6'h04;
    localparam logic [ADDR_W-1:0] A_LEN  = 6'h24;
    localparam logic [ADDR_W-1:0] A_CTL  = 6'h28;
    localparam logic [ADDR_W-1:0] A_CS   = 6'h2C;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OP,
        PH_WR,
        PH_RD,
        PH_FIN
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] op;
        logic [CNT_W-1:0] wr;
        logic [CNT_W-1:0] rd;
    } plan_t;

    // Unpack the length register and clamp each count to its buffer size.
    function automatic plan_t decode_len(input logic [31:0] r);
        plan_t p;
        p.op = (CNT_W'(r[31:24]) > OP_MAX) ? OP_MAX : CNT_W'(r[31:24]);
        p.rd = (CNT_W'(r[20:12]) > DB_MAX) ? DB_MAX : CNT_W'(r[20:12]);
        p.wr = (CNT_W'(r[8:0])   > DB_MAX) ? DB_MAX : CNT_W'(r[8:0]);
        return p;
    endfunction

    // Fixed phase order; zero-length phases are skipped.
    function automatic phase_e next_ph(input phase_e cur, input plan_t p);
        phase_e n;
        n = PH_IDLE;
        case (cur)
            PH_IDLE: begin
                if (p.op != '0)      n = PH_OP;
                else if (p.wr != '0) n = PH_WR;
                else if (p.rd != '0) n = PH_RD;
                else                 n = PH_FIN;
            end
            PH_OP: begin
                if (p.wr != '0)      n = PH_WR;
                else if (p.rd != '0) n = PH_RD;
                else                 n = PH_IDLE;
            end
            PH_WR: begin
                if (p.rd != '0)      n = PH_RD;
                else                 n = PH_IDLE;
            end
            default: n = PH_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
    import spi_eng_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          wdata,
    input  logic                 busy,
    input  logic                 rx_we,
    input  logic [IDX_W-1:0]     rx_pos,
    input  logic                 rx_bit,
    output logic [31:0]          rdata,
    output logic [31:0]          opc_q,
    output logic [31:0]          len_q,
    output logic [DBUF_BITS-1:0] dbuf_q,
    output logic                 cs_q,
    output logic                 start
);

    assign start = we && (addr == A_CTL) && wdata[0] && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            opc_q  <= '0;
            len_q  <= '0;
            dbuf_q <= '0;
            cs_q   <= 1'b0;
        end else begin
            if (we && addr == A_CS)
                cs_q <= wdata[0];
            if (we && !busy) begin
                if (addr == A_OPC) opc_q <= wdata;
                if (addr == A_LEN) len_q <= wdata;
                for (int w = 0; w < DBUF_WORDS; w++) begin
                    if (addr == ADDR_W'(int'(A_DAT0) + 4 * w))
                        dbuf_q[32*w +: 32] <= wdata;
                end
            end
            if (rx_we)
                dbuf_q[rx_pos] <= rx_bit;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_OPC) rdata = opc_q;
        if (addr == A_LEN) rdata = len_q;
        if (addr == A_CTL) rdata = {31'b0, busy};
        if (addr == A_CS)  rdata = {31'b0, cs_q};
        for (int w = 0; w < DBUF_WORDS; w++) begin
            if (addr == ADDR_W'(int'(A_DAT0) + 4 * w))
                rdata = dbuf_q[32*w +: 32];
        end
    end

    AST_BUF_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (busy && !rx_we) |=> $stable(dbuf_q)); // R10
    AST_OPC_LOCKED: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(opc_q)); // R10
    AST_LEN_LOCKED: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(len_q)); // R10
    AST_CS_ONLY_SW: assert property (@(posedge clk) disable iff (rst)
        !(we && addr == A_CS) |=> $stable(cs_q)); // R11

endmodule

// File: rtl/spi_eng_seq.sv
module spi_eng_seq
    import spi_eng_pkg::*;
#(
    parameter int SCLK_HALF = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [31:0]          len_raw,
    input  logic [31:0]          opcode,
    input  logic [DBUF_BITS-1:0] dbuf,
    input  logic                 miso,
    output logic                 busy,
    output logic                 sclk,
    output logic                 mosi,
    output logic                 rx_we,
    output logic [IDX_W-1:0]     rx_pos,
    output logic                 rx_bit
);

    localparam int DIV_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCLK_HALF - 1);

    phase_e           phase_q;
    plan_t            plan_q;
    plan_t            plan_new;
    logic [IDX_W-1:0] bit_q;
    logic [DIV_W-1:0] div_q;
    logic             sclk_q;
    logic             shifting;
    logic             tick;
    logic             last_bit;
    logic [CNT_W-1:0] cur_len;
    logic [IDX_W-1:0] buf_idx;

    assign plan_new = decode_len(len_raw);
    assign shifting = (phase_q == PH_OP) || (phase_q == PH_WR) || (phase_q == PH_RD);
    assign tick     = shifting && (div_q == DIV_LAST);
    assign buf_idx  = {bit_q[IDX_W-1:3], ~bit_q[2:0]};

    always_comb begin
        case (phase_q)
            PH_OP:   cur_len = plan_q.op;
            PH_WR:   cur_len = plan_q.wr;
            PH_RD:   cur_len = plan_q.rd;
            default: cur_len = '0;
        endcase
    end

    assign last_bit = (CNT_W'(bit_q) == cur_len - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            plan_q  <= '0;
            bit_q   <= '0;
            div_q   <= '0;
            sclk_q  <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        plan_q  <= plan_new;
                        phase_q <= next_ph(PH_IDLE, plan_new);
                        bit_q   <= '0;
                        div_q   <= '0;
                        sclk_q  <= 1'b0;
                    end
                end
                PH_FIN: phase_q <= PH_IDLE;
                default: begin
                    if (tick) begin
                        div_q  <= '0;
                        sclk_q <= ~sclk_q;
                        if (sclk_q) begin
                            if (last_bit) begin
                                phase_q <= next_ph(phase_q, plan_q);
                                bit_q   <= '0;
                            end else begin
                                bit_q <= bit_q + 1'b1;
                            end
                        end
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        case (phase_q)
            PH_OP:   mosi = opcode[~bit_q[4:0]];
            PH_WR:   mosi = dbuf[buf_idx];
            default: mosi = 1'b0;
        endcase
    end

    assign busy   = (phase_q != PH_IDLE);
    assign sclk   = sclk_q;
    assign rx_we  = (phase_q == PH_RD) && tick && !sclk_q;
    assign rx_pos = buf_idx;
    assign rx_bit = miso;

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start |=> busy); // R9
    AST_EMPTY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (start && decode_len(len_raw) == '0) |=> busy ##1 !busy); // R9
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk_q); // R8
    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (sclk_q && $past(sclk_q)) |-> $stable(mosi)); // R8

endmodule

// File: rtl/hdx_spi_engine.sv
module hdx_spi_engine
    import spi_eng_pkg::*;
#(
    parameter int SCLK_HALF = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);

    logic                 busy;
    logic                 start;
    logic                 rx_we;
    logic [IDX_W-1:0]     rx_pos;
    logic                 rx_bit;
    logic [31:0]          opc_q;
    logic [31:0]          len_q;
    logic [DBUF_BITS-1:0] dbuf_q;
    logic                 cs_q;

    spi_eng_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .busy   (busy),
        .rx_we  (rx_we),
        .rx_pos (rx_pos),
        .rx_bit (rx_bit),
        .rdata  (reg_rdata),
        .opc_q  (opc_q),
        .len_q  (len_q),
        .dbuf_q (dbuf_q),
        .cs_q   (cs_q),
        .start  (start)
    );

    spi_eng_seq #(.SCLK_HALF(SCLK_HALF)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .len_raw (len_q),
        .opcode  (opc_q),
        .dbuf    (dbuf_q),
        .miso    (spi_miso),
        .busy    (busy),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .rx_we   (rx_we),
        .rx_pos  (rx_pos),
        .rx_bit  (rx_bit)
    );

    assign spi_cs_n = ~cs_q;

endmodule

// File: tb/sim_hdx_spi_engine.sv
module sim_hdx_spi_engine;
    import spi_eng_pkg::*;

    localparam int HALF = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sclk, mosi, miso, cs_n;

    always #2.5 clk = ~clk;

    hdx_spi_engine #(.SCLK_HALF(HALF)) u0 (
        .clk(clk), .rst(rst), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso),
        .spi_cs_n(cs_n)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int rises = 0;
    int slave_bit = 0;
    int last_rise = -1;
    int period_bad = 0;
    int hold_bad = 0;
    logic [7:0] exp_q[$];
    logic [7:0] model[DBUF_BYTES];
    logic [7:0] mon_sh = '0;
    int mon_n = 0;
    logic prev_sclk = 1'b0;
    logic prev_mosi = 1'b0;
    logic [7:0] slave_byte;

    function automatic logic [7:0] pat(input int n);
        return 8'(n * 37 + 11);
    endfunction

    function automatic logic [31:0] mk_len(input int op, input int wrb, input int rdb);
        return {8'(op), 3'b0, 9'(rdb), 3'b0, 9'(wrb)};
    endfunction

    always @(posedge clk) cyc++;

    // Slave model: streams pat() bytes MSB first, advancing on each falling SCLK.
    always_comb begin
        slave_byte = pat(slave_bit >> 3);
        miso = slave_byte[3'd7 - 3'(slave_bit)];
    end
    always @(negedge sclk) if (!rst) slave_bit++;

    // Monitor: rebuild MOSI bytes at rising SCLK and compare against the scoreboard.
    always @(posedge sclk) begin
        if (!rst) begin
            rises++;
            if (last_rise >= 0 && (cyc - last_rise) != 2 * HALF) period_bad++;
            last_rise = cyc;
            mon_sh = {mon_sh[6:0], mosi};
            mon_n++;
            if (mon_n == 8) begin
                mon_n = 0;
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL R4 unexpected mosi byte act=%02h exp=none", mon_sh);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    if (e !== mon_sh) begin
                        bad++;
                        $display("FAIL R4/R5/R6 mosi byte act=%02h exp=%02h", mon_sh, e);
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (sclk && prev_sclk && mosi !== prev_mosi) hold_bad++;
            prev_sclk = sclk;
            prev_mosi = mosi;
        end
    end

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%08h exp=%08h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_now(input logic [5:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_now(a, d);
    endtask

    task automatic wdat(input int w, input logic [31:0] d);
        wr(6'(4 + 4 * w), d);
        for (int b = 0; b < 4; b++) model[4*w+b] = d[8*b +: 8];
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        int n;
        n = 0;
        do begin
            rd(A_CTL, v);
            n++;
        end while (v[0] && n < 20000);
        if (n >= 20000) check(1'b0, "R9", "busy never fell", v, 32'h0);
    endtask

    task automatic xfer(input logic [31:0] opc, input int opf, input int wrf, input int rdf);
        int eo, ew, er, base, r0;
        logic [31:0] v;
        eo = (opf > 32) ? 32 : opf;
        ew = (wrf > 256) ? 256 : wrf;
        er = (rdf > 256) ? 256 : rdf;
        wr(A_OPC, opc);
        wr(A_LEN, mk_len(opf, wrf, rdf));
        for (int k = 0; k < eo / 8; k++) exp_q.push_back(opc[31-8*k -: 8]);
        for (int k = 0; k < ew / 8; k++) exp_q.push_back(model[k]);
        for (int k = 0; k < er / 8; k++) exp_q.push_back(8'h00);
        base = slave_bit + eo + ew;
        r0 = rises;
        last_rise = -1;
        wr(A_CTL, 32'h1);
        rd_now(A_CTL, v);
        check(v[0] == 1'b1, "R9", "busy after start", v, 32'h1);
        wait_idle();
        check((rises - r0) == eo + ew + er, "R3", "sclk pulse count",
              32'(rises - r0), 32'(eo + ew + er));
        for (int k = 0; k < er / 8; k++) model[k] = pat(base / 8 + k);
        for (int w = 0; w < (er / 8 + 3) / 4; w++) begin
            rd(6'(4 + 4 * w), v);
            check(v === {model[4*w+3], model[4*w+2], model[4*w+1], model[4*w]},
                  "R7", "read data word", v,
                  {model[4*w+3], model[4*w+2], model[4*w+1], model[4*w]});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] keep_opc;
        int r0;
        for (int k = 0; k < DBUF_BYTES; k++) model[k] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_CTL, v);  check(v == 32'h0, "R1", "ctrl after reset", v, 32'h0);
        rd(A_OPC, v);  check(v == 32'h0, "R1", "opcode after reset", v, 32'h0);
        rd(A_LEN, v);  check(v == 32'h0, "R1", "len after reset", v, 32'h0);
        rd(A_DAT0, v); check(v == 32'h0, "R1", "data0 after reset", v, 32'h0);
        check(cs_n == 1'b1, "R1", "cs_n after reset", 32'(cs_n), 32'h1);
        check(sclk == 1'b0 && mosi == 1'b0, "R1", "sclk/mosi after reset",
              {30'b0, sclk, mosi}, 32'h0);

        // R2 register readback
        wr(A_OPC, 32'h12345678); rd(A_OPC, v);
        check(v == 32'h12345678, "R2", "opcode readback", v, 32'h12345678);
        wdat(3, 32'hCAFEF00D); rd(6'h10, v);
        check(v == 32'hCAFEF00D, "R2", "data word3 readback", v, 32'hCAFEF00D);
        wr(A_LEN, 32'h0801_2010); rd(A_LEN, v);
        check(v == 32'h0801_2010, "R2", "len readback", v, 32'h0801_2010);
        wr(A_CS, 32'h1); rd(A_CS, v);
        check(v == 32'h1, "R2", "cs readback", v, 32'h1);
        check(cs_n == 1'b0, "R11", "cs_n follows register", 32'(cs_n), 32'h0);

        // R9 all-zero transaction
        wr(A_LEN, 32'h0);
        r0 = rises;
        wr(A_CTL, 32'h1);
        rd_now(A_CTL, v); check(v[0] == 1'b1, "R9", "empty busy cycle 1", v, 32'h1);
        rd(A_CTL, v);     check(v[0] == 1'b0, "R9", "empty busy cycle 2", v, 32'h0);
        check(rises == r0, "R9", "empty no sclk", 32'(rises - r0), 32'h0);

        // R5 single command byte, left-aligned
        xfer(32'hA5000000, 8, 0, 0);

        // R4 R6 R7 all three phases
        wdat(0, 32'hDDCCBBAA);
        xfer(32'h03112233, 32, 32, 32);

        // R6 maximum write: 4 command bytes plus 32 buffer bytes
        for (int w = 0; w < DBUF_WORDS; w++) wdat(w, {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)} ^ 32'h5A5A5A5A);
        xfer(32'h0B0C0D0E, 32, 256, 0);

        // R7 maximum read of 32 bytes
        xfer(32'h0, 0, 0, 256);

        // R4 phase skipping
        wdat(0, 32'h00009C3E);
        xfer(32'h0, 0, 16, 0);
        xfer(32'h9F420000, 16, 0, 24);

        // R3 clamping of oversized fields
        xfer(32'hC1C2C3C4, 255, 511, 0);
        xfer(32'h0, 0, 0, 504);

        // R10 writes ignored while busy, R11 cs writable while busy
        wr(A_CS, 32'h0);
        check(cs_n == 1'b1, "R11", "cs_n released by software", 32'(cs_n), 32'h1);
        wdat(7, 32'h77777777);
        rd(A_OPC, keep_opc);
        wr(A_LEN, mk_len(0, 64, 0));
        for (int k = 0; k < 8; k++) exp_q.push_back(model[k]);
        r0 = rises;
        last_rise = -1;
        wr(A_CTL, 32'h1);
        wr(6'h20, 32'hBAD0BAD0);
        wr(A_OPC, 32'hFFFFFFFF);
        wr(A_LEN, 32'h0);
        wr(A_CTL, 32'h1);
        wr(A_CS, 32'h1);
        check(cs_n == 1'b0, "R11", "cs_n set while busy", 32'(cs_n), 32'h0);
        wait_idle();
        check((rises - r0) == 64, "R10", "pulses unchanged by busy writes", 32'(rises - r0), 32'd64);
        rd(6'h20, v);  check(v == 32'h77777777, "R10", "data word7 kept", v, 32'h77777777);
        rd(A_OPC, v);  check(v == keep_opc, "R10", "opcode kept", v, keep_opc);
        rd(A_LEN, v);  check(v == mk_len(0, 64, 0), "R10", "len kept", v, mk_len(0, 64, 0));
        repeat (20) @(negedge clk);
        rd(A_CTL, v);  check(v[0] == 1'b0, "R10", "no relaunch from busy start", v, 32'h0);
        check((rises - r0) == 64, "R10", "no extra pulses", 32'(rises - r0), 32'd64);

        // R11 transactions leave chip select alone
        check(cs_n == 1'b0, "R11", "cs_n held after transaction", 32'(cs_n), 32'h0);
        wr(A_CS, 32'h0);
        xfer(32'h66000000, 8, 0, 8);
        check(cs_n == 1'b1, "R11", "cs_n stays high across transaction", 32'(cs_n), 32'h1);

        // R8 timing summary
        check(sclk == 1'b0, "R8", "sclk idle low", 32'(sclk), 32'h0);
        check(period_bad == 0, "R8", "sclk period violations", 32'(period_bad), 32'h0);
        check(hold_bad == 0, "R8", "mosi moved while sclk high", 32'(hold_bad), 32'h0);
        check(exp_q.size() == 0, "R4", "scoreboard drained", 32'(exp_q.size()), 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule